// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block does the data work of an 8-bit accumulator CPU. Each cycle with `valid_i` high, it takes an operation code, the accumulator, the X and Y index registers, one operand byte and the current status byte. One clock later it returns a result byte, a destination code and the updated status byte. The destination code tells the surrounding datapath where to write the result: the accumulator, X, the memory operand, or nowhere.

The operations are load, AND, OR, XOR, add with carry, subtract with borrow, compare against A, X or Y, bit test, increment, decrement, shift left, logical shift right, rotate left, rotate right, and a combined operation that subtracts the operand from (A AND X) and writes the result to X. Each operation changes only the flags it defines. All other status bits pass through unchanged.

For read-modify-write operations, the caller places the byte to be modified on `opnd_i`. This includes the accumulator when the accumulator itself is being modified. Decimal arithmetic, instruction decoding, memory access and cycle timing belong to other blocks.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are: 0 load, 1 AND, 2 OR, 3 XOR, 4 add with carry, 5 subtract with borrow, 6 compare A, 7 compare X, 8 compare Y, 9 bit test, 10 increment, 11 decrement, 12 shift left, 13 shift right, 14 rotate left, 15 rotate right, 16 and-subtract. Results appear one clock after the input. `valid_o` is `valid_i` delayed by one clock.
- R2: Load, AND, OR and XOR produce, respectively, the operand, A&operand, A|operand and A^operand. Their destination is 1 (accumulator). They set Z when the result is zero and copy result bit 7 into N.
- R3: Add with carry gives A+operand+C, with destination 1. C takes the ninth bit. V is set when A and the operand share a sign and the result sign differs from A. N and Z follow the result.
- R4: Subtract gives A-operand-(1-C), with destination 1. C is set when no borrow occurs. V is set when A and the operand differ in sign and the result sign differs from A. N and Z follow the result.
- R5: Compare subtracts the operand from A, X or Y. The result output is the low byte of the difference and the destination is 0 (none). N and Z follow the difference and C is set when there is no borrow. V is unchanged.
- R6: Bit test outputs A with destination 0. Z is set when A&operand is zero. N takes operand bit 7 and V takes operand bit 6. C is unchanged.
- R7: Increment and decrement of the operand wrap modulo 256, with destination 3 (memory operand). Only N and Z change.
- R8: Shift left moves operand bit 7 into C. Shift right moves operand bit 0 into C, always clears N, and fills bit 7 with 0. Destination is 3 and Z follows the result.
- R9: Rotate left puts the old C into bit 0 and the old bit 7 into C. Rotate right puts the old C into bit 7 and the old bit 0 into C. Destination is 3, and N and Z follow the result.
- R10: And-subtract gives (A&X)-operand, with destination 2 (X). N and Z follow the result, C is set when there is no borrow, and V is unchanged.
- R11: Status layout is C bit 0, Z bit 1, I bit 2, D bit 3, B bit 4, bit 5, V bit 6, N bit 7. Bits 2 to 4 always pass through unchanged. Bit 5 of `status_o` is always 1.
- R12: Codes 17 to 31 produce result 0 and destination 0. They pass the status through, with bit 5 forced to 1.
- R13: While `rst_ni` is low, the outputs are: `valid_o` 0, result 0, destination 0, status 8'h20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operation valid |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator |
| xr_i | input | 8 | X register |
| yr_i | input | 8 | Y register |
| opnd_i | input | 8 | Operand byte |
| status_i | input | 8 | Current status byte |
| valid_o | output | 1 | Output valid |
| result_o | output | 8 | Result byte |
| dest_o | output | 2 | Destination: 0 none, 1 A, 2 X, 3 memory operand |
| status_o | output | 8 | Updated status byte |

## Verification
The only internal state is the output register, so a wrong internal value shows up at the ports on the single cycle after the operation it belongs to. The more likely errors are in the routing:
- a mis-steered adder input, such as the wrong index register or a wrong carry-in;
- a flag write mask that touches a flag the operation does not define.

Both appear one cycle after the offending operation, as a wrong result or a wrong status bit. The directed cases therefore pair each operation with an input status whose undefined flags are set, so that a stray write changes a visible bit. They also use operands at the sign and carry boundaries, so that overflow and borrow are exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int STATUS_W = 8;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 6;
  localparam int FLG_N = 7;
  localparam int FLG_ONE = 5;
  localparam logic [STATUS_W-1:0] STATUS_RST = 8'h20;

  typedef enum logic [4:0] {
    OP_LOAD = 5'd0, OP_AND = 5'd1, OP_OR = 5'd2, OP_XOR = 5'd3,
    OP_ADC = 5'd4, OP_SBC = 5'd5, OP_CMPA = 5'd6, OP_CMPX = 5'd7,
    OP_CMPY = 5'd8, OP_BIT = 5'd9, OP_INC = 5'd10, OP_DEC = 5'd11,
    OP_ASL = 5'd12, OP_LSR = 5'd13, OP_ROL = 5'd14, OP_ROR = 5'd15,
    OP_ANDSUB = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_ACC = 2'd1, DST_XREG = 2'd2, DST_MEM = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    LG_PASS = 2'd0, LG_AND = 2'd1, LG_OR = 2'd2, LG_XOR = 2'd3
  } logic_sel_e;

  typedef enum logic [2:0] {
    SH_INC = 3'd0, SH_DEC = 3'd1, SH_ASL = 3'd2,
    SH_LSR = 3'd3, SH_ROL = 3'd4, SH_ROR = 3'd5
  } shift_sel_e;
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic_sel_e   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         and_zero_o
);
  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
  end

  assign and_zero_o = ~|(a_i & b_i);
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  // Subtraction as a + ~b + cin: carry out equals "no borrow"
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign sum    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign res_o  = sum[W-1:0];
  assign cout_o = sum[W];
  assign ovf_o  = ~(a_i[W-1] ^ b_eff[W-1]) & (a_i[W-1] ^ sum[W-1]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_sel_e   sel_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res_o  = b_i;
    cout_o = cin_i;
    unique case (sel_i)
      SH_INC: res_o = b_i + ONE;
      SH_DEC: res_o = b_i - ONE;
      SH_ASL: begin res_o = {b_i[W-2:0], 1'b0};  cout_o = b_i[W-1]; end
      SH_LSR: begin res_o = {1'b0, b_i[W-1:1]};  cout_o = b_i[0];   end
      SH_ROL: begin res_o = {b_i[W-2:0], cin_i}; cout_o = b_i[W-1]; end
      SH_ROR: begin res_o = {cin_i, b_i[W-1:1]}; cout_o = b_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [4:0]          op_i,
  input  logic [W-1:0]        acc_i,
  input  logic [W-1:0]        xr_i,
  input  logic [W-1:0]        yr_i,
  input  logic [W-1:0]        opnd_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                valid_o,
  output logic [W-1:0]        result_o,
  output logic [1:0]          dest_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int WM_C = 0, WM_Z = 1, WM_V = 2, WM_N = 3;

  alu_op_e      op;
  logic_sel_e   lg_sel;
  shift_sel_e   sh_sel;
  logic [W-1:0] lg_res, as_res, sh_res, as_a;
  logic         lg_and_zero, as_sub, as_cin, as_cout, as_ovf, sh_cout;

  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_PASS;
    endcase
    unique case (op)
      OP_DEC:  sh_sel = SH_DEC;
      OP_ASL:  sh_sel = SH_ASL;
      OP_LSR:  sh_sel = SH_LSR;
      OP_ROL:  sh_sel = SH_ROL;
      OP_ROR:  sh_sel = SH_ROR;
      default: sh_sel = SH_INC;
    endcase
    unique case (op)
      OP_CMPX:   as_a = xr_i;
      OP_CMPY:   as_a = yr_i;
      OP_ANDSUB: as_a = acc_i & xr_i;
      default:   as_a = acc_i;
    endcase
  end

  assign as_sub = (op != OP_ADC);
  assign as_cin = (op == OP_ADC || op == OP_SBC) ? status_i[FLG_C] : 1'b1;

  alu8_logic #(.W(W)) i_logic (
    .sel_i(lg_sel), .a_i(acc_i), .b_i(opnd_i),
    .res_o(lg_res), .and_zero_o(lg_and_zero)
  );

  alu8_addsub #(.W(W)) i_addsub (
    .a_i(as_a), .b_i(opnd_i), .sub_i(as_sub), .cin_i(as_cin),
    .res_o(as_res), .cout_o(as_cout), .ovf_o(as_ovf)
  );

  alu8_shift #(.W(W)) i_shift (
    .sel_i(sh_sel), .b_i(opnd_i), .cin_i(status_i[FLG_C]),
    .res_o(sh_res), .cout_o(sh_cout)
  );

  logic [W-1:0]        res_n;
  dest_e               dest_n;
  logic [3:0]          wmask;
  logic                fc, fz, fv, fn;
  logic [STATUS_W-1:0] status_n;

  always_comb begin
    res_n  = '0;
    dest_n = DST_NONE;
    wmask  = '0;
    fc     = 1'b0;
    fv     = 1'b0;
    unique case (op)
      OP_LOAD, OP_AND, OP_OR, OP_XOR: begin
        res_n = lg_res; dest_n = DST_ACC;
        wmask = 4'b1010;
      end
      OP_ADC, OP_SBC: begin
        res_n = as_res; dest_n = DST_ACC;
        wmask = 4'b1111; fc = as_cout; fv = as_ovf;
      end
      OP_CMPA, OP_CMPX, OP_CMPY: begin
        res_n = as_res; wmask = 4'b1011; fc = as_cout;
      end
      OP_ANDSUB: begin
        res_n = as_res; dest_n = DST_XREG;
        wmask = 4'b1011; fc = as_cout;
      end
      OP_BIT: begin
        res_n = acc_i; wmask = 4'b1110; fv = opnd_i[W-2];
      end
      OP_INC, OP_DEC: begin
        res_n = sh_res; dest_n = DST_MEM; wmask = 4'b1010;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_n = sh_res; dest_n = DST_MEM;
        wmask = 4'b1011; fc = sh_cout;
      end
      default: ;
    endcase
    fz = (op == OP_BIT) ? lg_and_zero : ~|res_n;
    fn = (op == OP_BIT) ? opnd_i[W-1] : res_n[W-1];

    status_n = status_i;
    if (wmask[WM_C]) status_n[FLG_C] = fc;
    if (wmask[WM_Z]) status_n[FLG_Z] = fz;
    if (wmask[WM_V]) status_n[FLG_V] = fv;
    if (wmask[WM_N]) status_n[FLG_N] = fn;
    status_n[FLG_ONE] = 1'b1;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o  <= 1'b0;
          result_o <= '0;
          dest_o   <= DST_NONE;
          status_o <= STATUS_RST;
        end else begin
          valid_o  <= valid_i;
          result_o <= res_n;
          dest_o   <= dest_n;
          status_o <= status_n;
        end
      end
    end else begin : g_comb
      assign valid_o  = valid_i;
      assign result_o = res_n;
      assign dest_o   = dest_n;
      assign status_o = status_n;
    end
  endgenerate
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [4:0]          op_i,
  input logic [W-1:0]        opnd_i,
  input logic [STATUS_W-1:0] status_i,
  input logic                valid_o,
  input logic [W-1:0]        result_o,
  input logic [1:0]          dest_o,
  input logic [STATUS_W-1:0] status_o
);
  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R11
  sys_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (status_o[4:2] == $past(status_i[4:2])) && status_o[FLG_ONE]);

  // R2
  nz_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dest_o != DST_NONE) |->
      (status_o[FLG_Z] == (result_o == '0)) && (status_o[FLG_N] == result_o[W-1]));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) inside {OP_CMPA, OP_CMPX, OP_CMPY}) |->
      (dest_o == DST_NONE) && (status_o[FLG_V] == $past(status_i[FLG_V])));

  // R6
  bit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == OP_BIT) |->
      (status_o[FLG_N] == $past(opnd_i[W-1])) && (status_o[FLG_V] == $past(opnd_i[W-2]))
      && (status_o[FLG_C] == $past(status_i[FLG_C])));

  // R7
  incdec_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) inside {OP_INC, OP_DEC}) |->
      (status_o[FLG_C] == $past(status_i[FLG_C])) && (status_o[FLG_V] == $past(status_i[FLG_V])));

  // R8
  lsr_nclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == OP_LSR) |->
      !status_o[FLG_N] && (status_o[FLG_C] == $past(opnd_i[0])));

  // R12
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) > 5'd16) |->
      (dest_o == DST_NONE) && (result_o == '0) && (status_o == ($past(status_i) | 8'h20)));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) i_alu8_core_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .opnd_i(opnd_i), .status_i(status_i), .valid_o(valid_o),
  .result_o(result_o), .dest_o(dest_o), .status_o(status_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, xr_i = '0, yr_i = '0, opnd_i = '0, status_i = 8'h20;
  logic       valid_o;
  logic [7:0] result_o;
  logic [1:0] dest_o;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;

  alu8_core i_alu8_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_i(acc_i), .xr_i(xr_i), .yr_i(yr_i), .opnd_i(opnd_i),
    .status_i(status_i), .valid_o(valid_o), .result_o(result_o),
    .dest_o(dest_o), .status_o(status_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [7:0] act_r, input logic [1:0] act_d,
                     input logic [7:0] act_s, input logic [7:0] exp_r,
                     input logic [1:0] exp_d, input logic [7:0] exp_s);
    checks++;
    if (act_r !== exp_r || act_d !== exp_d || act_s !== exp_s || valid_o !== 1'b1) begin
      errors++;
      $display("FAIL %s: got res=%h dst=%0d st=%h v=%b, exp res=%h dst=%0d st=%h v=1",
               tag, act_r, act_d, act_s, valid_o, exp_r, exp_d, exp_s);
    end
  endtask

  task automatic run(input string tag, input logic [4:0] op, input logic [7:0] a,
                     input logic [7:0] x, input logic [7:0] y, input logic [7:0] b,
                     input logic [7:0] st, input logic [7:0] exp_r,
                     input logic [1:0] exp_d, input logic [7:0] exp_s);
    @(negedge clk_i);
    op_i = op; acc_i = a; xr_i = x; yr_i = y; opnd_i = b; status_i = st; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(tag, result_o, dest_o, status_o, exp_r, exp_d, exp_s);
  endtask

  task automatic t_reset();
    checks++;
    if (valid_o !== 1'b0 || result_o !== 8'h00 || dest_o !== 2'd0 || status_o !== 8'h20) begin
      errors++;
      $display("FAIL R13: got v=%b res=%h dst=%0d st=%h, exp v=0 res=00 dst=0 st=20",
               valid_o, result_o, dest_o, status_o);
    end
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid_o got %b exp 0", valid_o);
    end
  endtask

  task automatic t_logic();
    run("R2 load zero", 5'd0, 8'h55, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 2'd1, 8'h22);
    run("R2 load neg",  5'd0, 8'h55, 8'h00, 8'h00, 8'h80, 8'h22, 8'h80, 2'd1, 8'hA0);
    run("R2 and",       5'd1, 8'hF0, 8'h00, 8'h00, 8'h0F, 8'h20, 8'h00, 2'd1, 8'h22);
    run("R2 or",        5'd2, 8'h81, 8'h00, 8'h00, 8'h02, 8'h61, 8'h83, 2'd1, 8'hE1);
    run("R2 xor",       5'd3, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h20, 8'h00, 2'd1, 8'h22);
  endtask

  task automatic t_arith();
    run("R3 adc ovf",   5'd4, 8'h50, 8'h00, 8'h00, 8'h50, 8'h20, 8'hA0, 2'd1, 8'hE0);
    run("R3 adc carry", 5'd4, 8'hFF, 8'h00, 8'h00, 8'h01, 8'h20, 8'h00, 2'd1, 8'h23);
    run("R3 adc cin",   5'd4, 8'h10, 8'h00, 8'h00, 8'h20, 8'h21, 8'h31, 2'd1, 8'h20);
    run("R4 sbc ovf",   5'd5, 8'h50, 8'h00, 8'h00, 8'hB0, 8'h21, 8'hA0, 2'd1, 8'hE0);
    run("R4 sbc brw",   5'd5, 8'h05, 8'h00, 8'h00, 8'h03, 8'h20, 8'h01, 2'd1, 8'h21);
    run("R4 sbc zero",  5'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h21, 8'h00, 2'd1, 8'h23);
  endtask

  task automatic t_compare();
    run("R5 cmpa eq",  5'd6, 8'h40, 8'h00, 8'h00, 8'h40, 8'h20, 8'h00, 2'd0, 8'h23);
    run("R5 cmpx lt",  5'd7, 8'h99, 8'h10, 8'h00, 8'h20, 8'h60, 8'hF0, 2'd0, 8'hE0);
    run("R5 cmpy gt",  5'd8, 8'h99, 8'h77, 8'h30, 8'h01, 8'h20, 8'h2F, 2'd0, 8'h21);
  endtask

  task automatic t_bit();
    run("R6 bit set",  5'd9, 8'h01, 8'h00, 8'h00, 8'hC0, 8'h21, 8'h01, 2'd0, 8'hE3);
    run("R6 bit clr",  5'd9, 8'h41, 8'h00, 8'h00, 8'h01, 8'hE0, 8'h41, 2'd0, 8'h20);
  endtask

  task automatic t_incdec();
    run("R7 inc wrap", 5'd10, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h61, 8'h00, 2'd3, 8'h63);
    run("R7 dec wrap", 5'd11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'hFF, 2'd3, 8'hA0);
  endtask

  task automatic t_shift();
    run("R8 asl",      5'd12, 8'h00, 8'h00, 8'h00, 8'h81, 8'h20, 8'h02, 2'd3, 8'h21);
    run("R8 lsr",      5'd13, 8'h00, 8'h00, 8'h00, 8'h01, 8'hA0, 8'h00, 2'd3, 8'h23);
    run("R9 rol",      5'd14, 8'h00, 8'h00, 8'h00, 8'h80, 8'h21, 8'h01, 2'd3, 8'h21);
    run("R9 ror out",  5'd15, 8'h00, 8'h00, 8'h00, 8'h01, 8'h20, 8'h00, 2'd3, 8'h23);
    run("R9 ror in",   5'd15, 8'h00, 8'h00, 8'h00, 8'h02, 8'h21, 8'h81, 2'd3, 8'hA0);
  endtask

  task automatic t_andsub();
    run("R10 nobrw",   5'd16, 8'hF3, 8'h0F, 8'h00, 8'h02, 8'h60, 8'h01, 2'd2, 8'h61);
    run("R10 brw",     5'd16, 8'h00, 8'hFF, 8'h00, 8'h01, 8'h20, 8'hFF, 2'd2, 8'hA0);
  endtask

  task automatic t_passthru();
    run("R11 sys bits", 5'd4, 8'h01, 8'h00, 8'h00, 8'h01, 8'h1C, 8'h02, 2'd1, 8'h3C);
    run("R12 unused",   5'd20, 8'hAA, 8'h55, 8'h11, 8'h22, 8'h0D, 8'h00, 2'd0, 8'h2D);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_idle();
    t_logic();
    t_arith();
    t_compare();
    t_bit();
    t_incdec();
    t_shift();
    t_andsub();
    t_passthru();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule